// File: doc/BRIEF.md
# Page Write Collector with Timed Program Cycle

This block sits behind the command decoder of a serial memory slave. When the decoder sees a write command with its start address, the block opens a page of `PAGE_BYTES` bytes: every data byte that follows is placed at the current in-page offset, marked as received, and the offset steps on. Only the low offset bits advance. The upper address bits stay fixed, so a long burst wraps inside the page and replaces what it wrote before.

The write goes ahead only if chip select rises exactly after a whole byte. The decoder reports that as `cs_on_boundary` together with the `cs_rise` pulse. The page is then scanned once, from the lowest offset to the highest, one offset per clock. Each received byte outside the protected region is sent to the array write port. If at least one byte reached the array, the block holds itself busy for `PROG_CYCLES` clocks, which stands in for the internal write time. It then pulses `done` and `wel_clr`, which clears the write-enable latch. While the block is busy it returns all ones on status reads and accepts only status-read commands.

Top module: `page_write_buffer`

## Requirements
- R1: A byte received at in-page offset k goes to address {upper bits of the start address, k}. The offset starts at the low OFF_W bits of the start address and increases by one per byte.
- R2: The offset wraps from PAGE_BYTES-1 to 0. A byte received at an offset that already holds one replaces it.
- R3: The page is committed only when `cs_rise` arrives with `cs_on_boundary` = 1 and at least one byte has been received. Otherwise the write is dropped: there are no array writes and `busy` stays low.
- R4: A write command that starts while `wel` = 0 is ignored. Its bytes reach neither the page nor the array.
- R5: Protection levels are encoded on `prot_lvl`: 0 protects nothing; 1 protects addresses whose top two bits are 11; 2 protects addresses whose top bit is 1; 3 protects all addresses. A protected byte is never written to the array.
- R6: In the commit scan, only offsets that received a byte produce `arr_we`. They appear in ascending offset order, one per clock. The scan starts on the clock after the `cs_rise` edge.
- R7: `busy` is high for PAGE_BYTES scan clocks and then for PROG_CYCLES program clocks. If the scan wrote nothing, `busy` is high only for the PAGE_BYTES scan clocks.
- R8: `done` and `wel_clr` each pulse once, on the last program clock. They do not pulse when the scan wrote nothing.
- R9: `sts_rd` is 8'hFF while `busy` is high and equals `sts_live` otherwise.
- R10: While `busy` is high, `cmd_allow` is 1 only for a valid command with `cmd_is_status` = 1. While `busy` is low it follows `cmd_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel | input | 1 | Current write-enable latch value |
| wr_begin | input | 1 | Pulse: a write command was decoded |
| wr_addr | input | ADDR_W | Start address of the write |
| byte_vld | input | 1 | Pulse: a data byte is complete |
| byte_dat | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip select deasserted |
| cs_on_boundary | input | 1 | With cs_rise: the deassertion followed a whole byte |
| prot_lvl | input | 2 | Block protection level |
| cmd_vld | input | 1 | A command opcode is presented |
| cmd_is_status | input | 1 | The presented opcode is a status read |
| cmd_allow | output | 1 | The presented command may proceed |
| sts_live | input | 8 | Status byte while idle |
| sts_rd | output | 8 | Status byte to shift out |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal cycle in progress |
| done | output | 1 | Pulse: program cycle finished |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
The hardest cases to reach are a burst long enough to wrap the page, and a scan that finds only protected bytes. In the second case the block has to skip the program window even though it already went busy. The bench drives a 34-byte burst that starts two bytes below the page end, so the first two offsets are overwritten before the commit. It also commits pages whose every byte lies in the region protected by levels 1 and 3, and it counts the busy clocks and the `done` pulses after each such commit. The wrong-boundary case and the `wel` = 0 case are checked by showing that nothing reaches the array port.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_PROG   = 2'd3
  } pwb_state_e;

  // protection decision from level and the two top address bits
  function automatic logic in_prot(input logic [1:0] lvl, input logic [1:0] top2);
    logic r;
    case (lvl)
      2'd0:    r = 1'b0;
      2'd1:    r = (top2 == 2'b11);
      2'd2:    r = top2[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_dat,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_dat,
  output logic             rd_mark,
  output logic             any_mark
);
  logic [7:0]            slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mark;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == OFF_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
        mark[g] <= 1'b0;
      end else if (clr) begin
        mark[g] <= 1'b0;
      end else if (hit) begin
        slot[g] <= wr_dat;
        mark[g] <= 1'b1;
      end
    end
  end

  assign rd_dat   = slot[rd_off];
  assign rd_mark  = mark[rd_off];
  assign any_mark = |mark;
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int PROG_CYCLES = 100000,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= CW'(PROG_CYCLES - 1);
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign last = running && (cnt == '0);
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int HI_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic              cs_rise,
  input  logic              cs_on_boundary,
  input  logic [1:0]        prot_lvl,
  input  logic              any_mark,
  input  logic              rd_mark,
  input  logic              timer_last,
  output logic              store_clr,
  output logic              store_wr,
  output logic [OFF_W-1:0]  fill_off,
  output logic [OFF_W-1:0]  scan_off,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              commit_go,
  output logic              abandon,
  output logic              timer_start,
  output logic              in_scan,
  output logic              in_prog
);
  pwb_state_e       st;
  logic [HI_W-1:0]  base;
  logic             hit_any;
  logic             scan_end;

  assign in_scan   = (st == ST_COMMIT);
  assign in_prog   = (st == ST_PROG);
  assign store_clr = (st == ST_IDLE) && wr_begin && wel;
  assign store_wr  = (st == ST_FILL) && byte_vld;
  assign commit_go = (st == ST_FILL) && cs_rise && cs_on_boundary && any_mark;
  assign abandon   = (st == ST_FILL) && cs_rise && !(cs_on_boundary && any_mark);
  assign arr_addr  = {base, scan_off};
  assign arr_we    = in_scan && rd_mark && !in_prot(prot_lvl, arr_addr[ADDR_W-1 -: 2]);
  assign scan_end  = in_scan && (scan_off == OFF_W'(PAGE_BYTES - 1));
  assign timer_start = scan_end && (hit_any || arr_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      base     <= '0;
      fill_off <= '0;
      scan_off <= '0;
      hit_any  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (store_clr) begin
            st       <= ST_FILL;
            base     <= wr_addr[ADDR_W-1:OFF_W];
            fill_off <= wr_addr[OFF_W-1:0];
          end
        end
        ST_FILL: begin
          if (store_wr) fill_off <= fill_off + 1'b1;
          if (commit_go) begin
            st       <= ST_COMMIT;
            scan_off <= '0;
            hit_any  <= 1'b0;
          end else if (abandon) begin
            st <= ST_IDLE;
          end
        end
        ST_COMMIT: begin
          hit_any  <= hit_any || arr_we;
          scan_off <= scan_off + 1'b1;
          if (scan_end) st <= timer_start ? ST_PROG : ST_IDLE;
        end
        default: begin
          if (timer_last) st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_BYTES = 32,
  parameter int PROG_CYCLES = 100000,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic              cs_rise,
  input  logic              cs_on_boundary,
  input  logic [1:0]        prot_lvl,
  input  logic              cmd_vld,
  input  logic              cmd_is_status,
  output logic              cmd_allow,
  input  logic [7:0]        sts_live,
  output logic [7:0]        sts_rd,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              busy,
  output logic              done,
  output logic              wel_clr
);
  logic             store_clr, store_wr, any_mark, rd_mark;
  logic [OFF_W-1:0] fill_off, scan_off;
  logic             commit_go, abandon, timer_start, timer_last, timer_run;
  logic             in_scan, in_prog;

  pwb_page_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(store_clr), .wr_en(store_wr),
    .wr_off(fill_off), .wr_dat(byte_dat), .rd_off(scan_off),
    .rd_dat(arr_wdata), .rd_mark(rd_mark), .any_mark(any_mark)
  );

  pwb_commit_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wel(wel), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary),
    .prot_lvl(prot_lvl), .any_mark(any_mark), .rd_mark(rd_mark),
    .timer_last(timer_last), .store_clr(store_clr), .store_wr(store_wr),
    .fill_off(fill_off), .scan_off(scan_off), .arr_we(arr_we), .arr_addr(arr_addr),
    .commit_go(commit_go), .abandon(abandon), .timer_start(timer_start),
    .in_scan(in_scan), .in_prog(in_prog)
  );

  pwb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(timer_start),
    .running(timer_run), .last(timer_last)
  );

  assign busy      = in_scan || in_prog;
  assign done      = in_prog && timer_last;
  assign wel_clr   = done;
  assign sts_rd    = busy ? 8'hFF : sts_live;
  assign cmd_allow = cmd_vld && (!busy || cmd_is_status);
endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              cs_on_boundary,
  input logic [1:0]        prot_lvl,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy,
  input logic              done
);
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_start_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_rise) && $past(cs_on_boundary)));

  p_no_prot_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !in_prot(prot_lvl, arr_addr[ADDR_W-1 -: 2]));
endmodule

bind page_write_buffer page_write_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary),
  .prot_lvl(prot_lvl), .arr_we(arr_we), .arr_addr(arr_addr), .busy(busy), .done(done)
);

// File: tb/page_write_buffer_tb_top.sv
module page_write_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int PG = 32;
  localparam int PROG = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wel = 0, wr_begin = 0, byte_vld = 0, cs_rise = 0, cs_on_boundary = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] byte_dat = '0, sts_live = 8'h0C;
  logic [1:0] prot_lvl = '0;
  logic cmd_vld = 0, cmd_is_status = 0;
  logic cmd_allow, arr_we, busy, done, wel_clr;
  logic [7:0] sts_rd, arr_wdata;
  logic [AW-1:0] arr_addr;

  int n_chk = 0, n_bad = 0;
  logic [AW+7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .PAGE_BYTES(PG), .PROG_CYCLES(PROG)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit prot(input logic [1:0] l, input logic [AW-1:0] a);
    if (l == 0) return 0;
    if (l == 1) return a >= 11'h600;
    if (l == 2) return a >= 11'h400;
    return 1;
  endfunction

  // monitor: array writes against the scoreboard (R1 R2 R6)
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (exp_q.size() == 0) check(0, "R6 unexpected write", {arr_addr, arr_wdata}, 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        check({arr_addr, arr_wdata} == e, "R1/R2 write addr,data", {arr_addr, arr_wdata}, e);
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                          input bit wl, input bit bnd, input logic [1:0] lvl, input string tag);
    logic [7:0] pg[PG];
    bit mk[PG];
    int acc = 0, any = 0, bcnt = 0, dcnt = 0, wcnt = 0, sts_ok = 1, cmd_ok = 1;
    int exp_busy;
    for (int k = 0; k < PG; k++) mk[k] = 0;
    for (int i = 0; i < n; i++) begin
      int off = (int'(a[4:0]) + i) % PG;
      pg[off] = seed + 8'(i * 7);
      mk[off] = 1;
      any = 1;
    end
    if (wl && bnd && any)
      for (int k = 0; k < PG; k++) begin
        logic [AW-1:0] ad = {a[AW-1:5], 5'(k)};
        if (mk[k] && !prot(lvl, ad)) begin exp_q.push_back({ad, pg[k]}); acc++; end
      end
    exp_busy = (wl && bnd && any) ? (acc > 0 ? PG + PROG : PG) : 0;
    @(negedge clk);
    prot_lvl = lvl; wel = wl; wr_addr = a; wr_begin = 1;
    @(negedge clk);
    wr_begin = 0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1; byte_dat = seed + 8'(i * 7);
      @(negedge clk);
    end
    byte_vld = 0;
    cs_rise = 1; cs_on_boundary = bnd;
    @(negedge clk);
    cs_rise = 0; cs_on_boundary = 0;
    for (int c = 0; c < PG + PROG + 6; c++) begin
      cmd_vld = 1; cmd_is_status = c[0];
      #1;
      if (busy) begin
        bcnt++;
        if (sts_rd != 8'hFF) sts_ok = 0;
        if (cmd_allow != c[0]) cmd_ok = 0;
      end else begin
        if (sts_rd != sts_live) sts_ok = 0;
        if (!cmd_allow) cmd_ok = 0;
      end
      if (done) dcnt++;
      if (wel_clr) wcnt++;
      @(negedge clk);
    end
    cmd_vld = 0;
    check(exp_q.size() == 0, {"R6 writes drained ", tag}, exp_q.size(), 0);
    exp_q.delete();
    check(bcnt == exp_busy, {"R7 busy length ", tag}, bcnt, exp_busy);
    check(dcnt == (acc > 0 ? 1 : 0), {"R8 done pulses ", tag}, dcnt, acc > 0);
    check(wcnt == dcnt, {"R8 wel_clr pulses ", tag}, wcnt, dcnt);
    check(sts_ok == 1, {"R9 status view ", tag}, sts_ok, 1);
    check(cmd_ok == 1, {"R10 command gate ", tag}, cmd_ok, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(!busy && !arr_we && !done && !wel_clr, "R7 reset idle", busy, 0);
        check(sts_rd == sts_live, "R9 reset status", sts_rd, sts_live);
        do_write(11'h045, 3, 8'h10, 1, 1, 0, "R1 basic");
        do_write(11'h07E, 34, 8'h30, 1, 1, 0, "R2 wrap");
        do_write(11'h100, 4, 8'h50, 1, 0, 0, "R3 off-boundary");
        do_write(11'h100, 0, 8'h50, 1, 1, 0, "R3 empty");
        do_write(11'h120, 5, 8'h60, 0, 1, 0, "R4 wel low");
        do_write(11'h7E0, 4, 8'h70, 1, 1, 1, "R5 lvl1 blocked");
        do_write(11'h5F0, 4, 8'h80, 1, 1, 1, "R5 lvl1 open");
        do_write(11'h3F0, 6, 8'h90, 1, 1, 2, "R5 lvl2 open");
        do_write(11'h010, 3, 8'hA0, 1, 1, 3, "R5 lvl3 blocked");
        do_write(11'h201, 32, 8'hB0, 1, 1, 0, "R6 full page");
      end
      begin
        repeat (20000) @(negedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule